// File: doc/BRIEF.md
# Transmit Flow-Control Credit Tracker

This block keeps the transmit-side flow-control credit balance that user logic must respect before it hands a packet to a PCI Express core. Credits are held as a header count and a data count for each of three traffic kinds: posted, non-posted and completion. The core starts a setup phase. In that phase the block copies the initial credit values the core offers and answers with a single acknowledge. From then on the block subtracts the cost of every packet it allows out and adds back whatever the core returns.

Before launching a packet, the transmit path puts the packet's kind and payload length on the query inputs. It reads `credit_ok` in the same cycle. It asserts `tx_send` only when `credit_ok` is high. The block applies the charge when that send is accepted. An initial value of zero marks that counter as unlimited. Any reset wipes the balance, and a fresh setup phase is then needed before any send is allowed.

Top module: `txfc_credit_tracker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fc_ready`, `init_ack` and `credit_ok` are low and every `avail_hdr`/`avail_dat` field reads zero.
- R2: On the first clock edge where `fc_ready` is low and `init_req` is high, the block loads all six counters from `init_hdr`/`init_dat`. Kind k uses bits [k*HDR_W +: HDR_W] and [k*DAT_W +: DAT_W], with kind codes posted=0, non-posted=1, completion=2. From the next cycle `fc_ready` is high.
- R3: `init_ack` is the only handshake output. It is high for exactly one cycle, the cycle right after the capture edge.
- R4: While `fc_ready` is high, `init_req` and the `init_*` values have no effect on any counter or output.
- R5: A packet of L payload DW costs one header credit and ceil(L/4) data credits of its kind. A length of 0 costs no data credit.
- R6: `credit_ok` is high only when `fc_ready` is high, `tx_kind` is 0, 1 or 2, that kind's header counter is at least 1 (or unlimited) and its data counter covers the cost (or is unlimited). Kind code 3 is never allowed.
- R7: An accepted send (`tx_send` with `credit_ok` high) lowers that kind's header counter by 1 and its data counter by the cost, as seen in the next cycle.
- R8: `tx_send` while `credit_ok` is low changes no counter.
- R9: When `ret_valid` is high and `fc_ready` is high, `ret_hdr`/`ret_dat` are added to kind `ret_kind`. A return and a charge to the same kind in one cycle are both applied.
- R10: A counter whose initial value was zero is unlimited. It reads zero, is never charged, ignores returns, and never blocks a send.
- R11: A return that would push a counter above its all-ones maximum leaves it at that maximum.
- R12: A reset after operation clears the balance. Sends stay blocked until a new setup phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Core-driven setup request |
| init_hdr | input | 3*HDR_W | Initial header credits, one field per kind |
| init_dat | input | 3*DAT_W | Initial data credits, one field per kind |
| init_ack | output | 1 | One-cycle setup acknowledge |
| fc_ready | output | 1 | Credits captured, counting active |
| tx_kind | input | 2 | Kind of the packet being queried or sent |
| tx_len_dw | input | LEN_W | Payload length in DW |
| tx_send | input | 1 | Send strobe, honoured only with credit_ok |
| credit_ok | output | 1 | Enough credit for the queried packet |
| ret_valid | input | 1 | Credit return strobe |
| ret_kind | input | 2 | Kind receiving the return |
| ret_hdr | input | HDR_W | Header credits returned |
| ret_dat | input | DAT_W | Data credits returned |
| avail_hdr | output | 3*HDR_W | Current header credits per kind |
| avail_dat | output | 3*DAT_W | Current data credits per kind |

## Verification
The first scripted run drains the posted kind with payload lengths of 0, 4, 5, 13 and 20 DW. This separates the ceil rounding from truncation, and separates a header shortage from a data shortage. Further scripted cases cover:
- a return and a charge in the same cycle, which exposes a lost update;
- large returns, which show whether the counters saturate or wrap;
- a setup request held while counting, which must be ignored;
- a non-posted kind with unlimited data and a completion kind with unlimited headers, which show each unlimited flag acting alone.

A randomized phase then mixes kinds 0 to 3, short and long lengths, and small returns against a behavioural balance compared every cycle.

// File: rtl/txfc_pkg.sv
package txfc_pkg;
  localparam int NUM_KINDS = 3;

  typedef enum logic [1:0] {
    FC_POSTED    = 2'd0,
    FC_NONPOSTED = 2'd1,
    FC_COMPL     = 2'd2,
    FC_NONE      = 2'd3
  } fc_kind_e;

  // Data credits for a payload: one credit per 4 DW, rounded up.
  function automatic int unsigned data_cost(int unsigned len_dw);
    return (len_dw + 32'd3) >> 2;
  endfunction

  // Counter update with a simultaneous charge and return, saturating at cap.
  function automatic int unsigned next_count(int unsigned cur, int unsigned dec,
                                             int unsigned inc, int unsigned cap);
    int unsigned sum;
    sum = cur - dec + inc;
    if (sum > cap) sum = cap;
    return sum;
  endfunction
endpackage

// File: rtl/txfc_init_ctl.sv
module txfc_init_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic init_req,
  output logic capture,
  output logic ready,
  output logic ack
);
  logic ready_q, ack_q;

  assign capture = !ready_q && init_req;
  assign ready   = ready_q;
  assign ack     = ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= capture;
      if (capture) ready_q <= 1'b1;
    end
  end

  // R3: acknowledge lasts exactly one cycle
  assert_ack_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);
  // R2: acknowledge comes together with ready
  assert_ack_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> ready_q);
  // R2: a capture edge leads to ready and ack
  assert_capture_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (ack_q && ready_q));
endmodule

// File: rtl/txfc_credit_slot.sv
module txfc_credit_slot
  import txfc_pkg::*;
#(
  parameter int HDR_W = 8,
  parameter int DAT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             active,
  input  logic [HDR_W-1:0] init_hdr,
  input  logic [DAT_W-1:0] init_dat,
  input  logic             consume,
  input  logic [DAT_W-1:0] need_dat,
  input  logic             ret_en,
  input  logic [HDR_W-1:0] ret_hdr,
  input  logic [DAT_W-1:0] ret_dat,
  output logic [HDR_W-1:0] hdr_q,
  output logic [DAT_W-1:0] dat_q,
  output logic             hdr_ok,
  output logic             dat_ok
);
  localparam int unsigned HDR_MAX = (32'd1 << HDR_W) - 32'd1;
  localparam int unsigned DAT_MAX = (32'd1 << DAT_W) - 32'd1;

  logic hdr_inf_q, dat_inf_q;
  logic [HDR_W-1:0] hdr_d;
  logic [DAT_W-1:0] dat_d;

  assign hdr_ok = hdr_inf_q || (hdr_q != '0);
  assign dat_ok = dat_inf_q || (dat_q >= need_dat);

  always_comb begin
    hdr_d = HDR_W'(next_count(32'(hdr_q), consume ? 32'd1 : 32'd0,
                              ret_en ? 32'(ret_hdr) : 32'd0, HDR_MAX));
    dat_d = DAT_W'(next_count(32'(dat_q), consume ? 32'(need_dat) : 32'd0,
                              ret_en ? 32'(ret_dat) : 32'd0, DAT_MAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q     <= '0;
      dat_q     <= '0;
      hdr_inf_q <= 1'b0;
      dat_inf_q <= 1'b0;
    end else if (capture) begin
      hdr_q     <= init_hdr;
      dat_q     <= init_dat;
      hdr_inf_q <= (init_hdr == '0);
      dat_inf_q <= (init_dat == '0);
    end else if (active) begin
      if (!hdr_inf_q) hdr_q <= hdr_d;
      if (!dat_inf_q) dat_q <= dat_d;
    end
  end

  // R7: a charge is only applied when credit covers it
  assert_charge_covered_R7: assert property (@(posedge clk) disable iff (!rst_n)
    consume |-> (hdr_ok && dat_ok));
  // R7: lone charge lowers the header count by one
  assert_hdr_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && consume && !ret_en && !hdr_inf_q) |=> (hdr_q == $past(hdr_q) - 1'b1));
  // R10: unlimited counters never move
  assert_inf_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_inf_q && !capture) |=> $stable(hdr_q));
  // R11: counters never wrap below their previous value on a lone return
  assert_no_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && ret_en && !consume && !capture) |=> (dat_q >= $past(dat_q)));
endmodule

// File: rtl/txfc_credit_tracker.sv
module txfc_credit_tracker
  import txfc_pkg::*;
#(
  parameter int HDR_W = 8,
  parameter int DAT_W = 12,
  parameter int LEN_W = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       init_req,
  input  logic [NUM_KINDS*HDR_W-1:0] init_hdr,
  input  logic [NUM_KINDS*DAT_W-1:0] init_dat,
  output logic                       init_ack,
  output logic                       fc_ready,
  input  logic [1:0]                 tx_kind,
  input  logic [LEN_W-1:0]           tx_len_dw,
  input  logic                       tx_send,
  output logic                       credit_ok,
  input  logic                       ret_valid,
  input  logic [1:0]                 ret_kind,
  input  logic [HDR_W-1:0]           ret_hdr,
  input  logic [DAT_W-1:0]           ret_dat,
  output logic [NUM_KINDS*HDR_W-1:0] avail_hdr,
  output logic [NUM_KINDS*DAT_W-1:0] avail_dat
);
  logic                 capture;
  logic                 tx_fire;
  logic [DAT_W-1:0]     need_dat;
  logic [NUM_KINDS-1:0] hdr_ok_v, dat_ok_v, consume_v, ret_v;
  logic                 sel_ok;

  assign need_dat = DAT_W'(data_cost(32'(tx_len_dw)));

  txfc_init_ctl u_init (
    .clk     (clk),
    .rst_n   (rst_n),
    .init_req(init_req),
    .capture (capture),
    .ready   (fc_ready),
    .ack     (init_ack)
  );

  always_comb begin
    sel_ok = 1'b0;
    for (int k = 0; k < NUM_KINDS; k++)
      if (tx_kind == 2'(k)) sel_ok = hdr_ok_v[k] && dat_ok_v[k];
  end

  assign credit_ok = fc_ready && sel_ok;
  assign tx_fire   = tx_send && credit_ok;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    assign consume_v[k] = tx_fire && (tx_kind == 2'(k));
    assign ret_v[k]     = ret_valid && (ret_kind == 2'(k));

    txfc_credit_slot #(.HDR_W(HDR_W), .DAT_W(DAT_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .active  (fc_ready),
      .init_hdr(init_hdr[k*HDR_W +: HDR_W]),
      .init_dat(init_dat[k*DAT_W +: DAT_W]),
      .consume (consume_v[k]),
      .need_dat(need_dat),
      .ret_en  (ret_v[k]),
      .ret_hdr (ret_hdr),
      .ret_dat (ret_dat),
      .hdr_q   (avail_hdr[k*HDR_W +: HDR_W]),
      .dat_q   (avail_dat[k*DAT_W +: DAT_W]),
      .hdr_ok  (hdr_ok_v[k]),
      .dat_ok  (dat_ok_v[k])
    );
  end

  // R12: nothing may be sent before the setup phase completes
  assert_blocked_unready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_ready |-> !credit_ok);
  // R6: kind code 3 is never allowed
  assert_kind3_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_kind == 2'd3) |-> !credit_ok);
  // R4: a setup request while counting changes nothing
  assert_reinit_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_ready && init_req && !tx_fire && !ret_valid) |=>
      ($stable(avail_hdr) && $stable(avail_dat) && !init_ack));
  // R8: a refused send leaves the balance alone
  assert_refused_send_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_ready && tx_send && !credit_ok && !ret_valid) |=>
      ($stable(avail_hdr) && $stable(avail_dat)));
endmodule

// File: tb/txfc_credit_tracker_tb_top.sv
`timescale 1ns/1ps
module txfc_credit_tracker_tb_top;
  localparam int HW = 8, DW = 12, LW = 11, NK = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic rst_n, init_req, tx_send, ret_valid;
  logic [NK*HW-1:0] init_hdr, avail_hdr;
  logic [NK*DW-1:0] init_dat, avail_dat;
  logic init_ack, fc_ready, credit_ok;
  logic [1:0] tx_kind, ret_kind;
  logic [LW-1:0] tx_len_dw;
  logic [HW-1:0] ret_hdr;
  logic [DW-1:0] ret_dat;

  txfc_credit_tracker #(.HDR_W(HW), .DAT_W(DW), .LEN_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_hdr(init_hdr),
    .init_dat(init_dat), .init_ack(init_ack), .fc_ready(fc_ready),
    .tx_kind(tx_kind), .tx_len_dw(tx_len_dw), .tx_send(tx_send),
    .credit_ok(credit_ok), .ret_valid(ret_valid), .ret_kind(ret_kind),
    .ret_hdr(ret_hdr), .ret_dat(ret_dat), .avail_hdr(avail_hdr),
    .avail_dat(avail_dat));

  int total = 0, bad = 0;
  bit finished = 0;
  string tag = "R1";

  // behavioural reference
  int m_hdr[NK], m_dat[NK];
  bit m_hinf[NK], m_dinf[NK];
  bit m_ready, m_ack;

  function automatic bit exp_ok();
    int cost;
    cost = (int'(tx_len_dw) + 3) / 4;
    if (!m_ready || tx_kind == 2'd3) return 0;
    return (m_hinf[tx_kind] || m_hdr[tx_kind] >= 1) &&
           (m_dinf[tx_kind] || m_dat[tx_kind] >= cost);
  endfunction

  task automatic chk(bit cond, string what, int act, int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < NK; k++) begin
      m_hdr[k] = 0; m_dat[k] = 0; m_hinf[k] = 0; m_dinf[k] = 0;
    end
    m_ready = 0; m_ack = 0;
  endtask

  task automatic compare();
    chk(fc_ready == m_ready, "fc_ready", fc_ready, m_ready);
    chk(init_ack == m_ack, "init_ack", init_ack, m_ack);
    chk(credit_ok == exp_ok(), "credit_ok", credit_ok, exp_ok());
    for (int k = 0; k < NK; k++) begin
      chk(int'(avail_hdr[k*HW +: HW]) == m_hdr[k], $sformatf("hdr[%0d]", k),
          int'(avail_hdr[k*HW +: HW]), m_hdr[k]);
      chk(int'(avail_dat[k*DW +: DW]) == m_dat[k], $sformatf("dat[%0d]", k),
          int'(avail_dat[k*DW +: DW]), m_dat[k]);
    end
  endtask

  task automatic model_step();
    bit fire;
    int cost;
    cost = (int'(tx_len_dw) + 3) / 4;
    fire = tx_send && exp_ok();
    if (!rst_n) begin model_clear(); return; end
    m_ack = 0;
    if (!m_ready) begin
      if (init_req) begin
        for (int k = 0; k < NK; k++) begin
          m_hdr[k] = int'(init_hdr[k*HW +: HW]);
          m_dat[k] = int'(init_dat[k*DW +: DW]);
          m_hinf[k] = (m_hdr[k] == 0);
          m_dinf[k] = (m_dat[k] == 0);
        end
        m_ready = 1; m_ack = 1;
      end
      return;
    end
    for (int k = 0; k < NK; k++) begin
      int h, d;
      h = m_hdr[k]; d = m_dat[k];
      if (fire && tx_kind == 2'(k)) begin h -= 1; d -= cost; end
      if (ret_valid && ret_kind == 2'(k)) begin h += int'(ret_hdr); d += int'(ret_dat); end
      if (h > 255) h = 255;
      if (d > 4095) d = 4095;
      if (!m_hinf[k]) m_hdr[k] = h;
      if (!m_dinf[k]) m_dat[k] = d;
    end
  endtask

  // inputs are set just after a falling edge; check, predict, wait one cycle
  task automatic tick();
    #1;
    if (!rst_n) model_clear();
    compare();
    model_step();
    @(negedge clk);
  endtask

  task automatic drv(bit s, int kd, int len, bit rv, int rk, int rh, int rd);
    tx_send = s; tx_kind = 2'(kd); tx_len_dw = LW'(len);
    ret_valid = rv; ret_kind = 2'(rk); ret_hdr = HW'(rh); ret_dat = DW'(rd);
  endtask

  task automatic set_init(int ph, int pd, int nh, int nd, int ch, int cd);
    init_hdr = {HW'(ch), HW'(nh), HW'(ph)};
    init_dat = {DW'(cd), DW'(nd), DW'(pd)};
  endtask

  initial begin
    #600000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_clear();
    rst_n = 0; init_req = 0;
    set_init(4, 8, 2, 0, 0, 20);
    drv(1, 0, 4, 1, 0, 3, 3);
    @(negedge clk);
    tag = "R1"; repeat (3) tick();
    rst_n = 1; tick();
    tag = "R8"; drv(1, 0, 4, 1, 0, 5, 5); repeat (2) tick();  // before setup
    tag = "R2"; drv(0, 0, 0, 0, 0, 0, 0); init_req = 1; tick();
    tag = "R3"; set_init(9, 9, 9, 9, 9, 9); tick();
    tag = "R4"; tick(); init_req = 0; tick();
    tag = "R5"; drv(1, 0, 5, 0, 0, 0, 0); tick();    // cost 2 -> 6
    drv(1, 0, 4, 0, 0, 0, 0); tick();                // cost 1 -> 5
    drv(1, 0, 0, 0, 0, 0, 0); tick();                // cost 0, hdr 1 left
    tag = "R6"; drv(1, 0, 21, 0, 0, 0, 0); tick();   // cost 6 > 5, refused
    tag = "R7"; drv(1, 0, 20, 0, 0, 0, 0); tick();   // cost 5 -> hdr 0 dat 0
    tag = "R8"; drv(1, 0, 0, 0, 0, 0, 0); tick();    // no header left
    tag = "R9"; drv(0, 0, 0, 1, 0, 2, 3); tick();
    drv(1, 0, 8, 1, 0, 1, 4); tick();                // charge and return together
    drv(1, 0, 13, 0, 0, 0, 0); tick();               // cost 4 vs 5
    tag = "R10"; drv(1, 1, 1000, 0, 0, 0, 0); repeat (2) tick();
    drv(1, 1, 4, 0, 0, 0, 0); tick();                // NP headers exhausted
    drv(1, 2, 16, 1, 2, 5, 0); repeat (4) tick();    // completion hdr unlimited
    drv(0, 0, 0, 1, 1, 0, 7); tick();                // return to unlimited data
    tag = "R6"; drv(1, 3, 0, 0, 0, 0, 0); tick();
    tag = "R11"; drv(0, 0, 0, 1, 0, 250, 4000); repeat (2) tick();
    drv(1, 0, 4, 1, 0, 200, 1); tick();
    tag = "R12"; drv(1, 0, 4, 0, 0, 0, 0); rst_n = 0; repeat (2) tick();
    rst_n = 1; repeat (2) tick();
    set_init(3, 10, 0, 6, 2, 0); init_req = 1; tick(); init_req = 0;
    tag = "R9";
    for (int i = 0; i < 3000; i++) begin
      drv($urandom_range(0, 1) == 1, $urandom_range(0, 3), $urandom_range(0, 40),
          $urandom_range(0, 3) == 0, $urandom_range(0, 3),
          $urandom_range(0, 2), $urandom_range(0, 6));
      tick();
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule